// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block translates a 48-bit virtual address into a physical address by reading a four-level radix page table held in memory. A translation request carries the virtual address together with two qualifiers: whether the access is a write and whether it comes from user mode. The root table base is supplied alongside. The walker then reads one 64-bit entry per level. It starts at the outermost table and moves inward, and each read address is built from the entry returned by the read before it.

At every level the walker checks the entry it has just read. An entry that is not present, that denies a write, or that denies a user access ends the walk at once. The block then reports a typed fault together with the level at which the walk stopped. When all four levels pass, the walker combines the frame from the last entry with the page offset. It also reports that entry's Accessed and Dirty bits. Only one walk runs at a time, and the result appears with a single-cycle `done` pulse.

Top module: `pt_walker`

## Requirements
- R1: After reset, `req_ready` is 1, and `done` and `mem_req_valid` are 0.
- R2: The virtual address supplies four 9-bit table indices, at bits 47:39, 38:30, 29:21 and 20:12. The walker reads these levels in the fixed order 4, 3, 2, 1. Each read address is the table base plus 8 times that level's index.
- R3: The level-4 table base is `root_base` bits 51:12, and bits 11:0 of `root_base` are ignored. Each later table base is bits 51:12 of the entry just read.
- R4: On success, `resp_paddr` is bits 51:12 of the level-1 entry concatenated with virtual address bits 11:0.
- R5: At most one memory read is outstanding, and the next read is issued only after the previous response arrives. A successful walk makes exactly four reads.
- R6: If bit 0 (present) of an entry is 0, the walk ends at that level with `resp_fault`=1 and `resp_cause`=1. No further read follows.
- R7: A write access to an entry whose bit 1 (writable) is 0 ends the walk at that level with `resp_cause`=2.
- R8: A user access to an entry whose bit 2 (user-allowed) is 0 ends the walk at that level with `resp_cause`=3. This check takes priority over R7. Supervisor accesses ignore bit 2.
- R9: On a fault, `resp_level` gives the level (4 down to 1) at which the walk stopped. On success, `resp_fault`, `resp_cause` and `resp_level` are all 0.
- R10: A request is accepted only while `req_ready` is 1. `req_ready` stays 0 from acceptance until `done`, and requests presented in that time are ignored.
- R11: `done` is high for exactly one cycle per accepted request.
- R12: On success, `resp_accessed` and `resp_dirty` equal bits 5 and 6 of the level-1 entry. On a fault, both are 0.
- R13: Bit 7 of an entry has no effect, so the walk always continues down to level 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request strobe |
| req_ready | output | 1 | Walker idle, request will be taken |
| req_vaddr | input | 48 | Virtual address to translate |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is from user mode |
| root_base | input | 52 | Root table base (bits 51:12 used) |
| mem_req_valid | output | 1 | Entry read strobe, one cycle |
| mem_req_addr | output | 52 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Entry read data valid |
| mem_rsp_data | input | 64 | Entry read data |
| done | output | 1 | Result valid pulse |
| resp_paddr | output | 52 | Translated physical address |
| resp_fault | output | 1 | Walk ended with a fault |
| resp_cause | output | 2 | 0 none, 1 not present, 2 write denied, 3 user denied |
| resp_level | output | 3 | Level at which the fault occurred, 0 on success |
| resp_accessed | output | 1 | Accessed bit of the final entry |
| resp_dirty | output | 1 | Dirty bit of the final entry |

## Verification
The properties assume that the memory side answers only while a read is outstanding, and only once per read. They also assume that the requester never sees `req_ready` and `done` in a conflicting order. The bench's memory model holds a single pending read and returns it after a fixed delay. It flags any second read that the walker issues while one is still pending. Requests sent while the walker is busy are lowered before the walk can finish. Any extra walk they started would therefore show up as an unexpected memory read.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  localparam int ENT_PRESENT  = 0;
  localparam int ENT_WRITABLE = 1;
  localparam int ENT_USER     = 2;
  localparam int ENT_ACCESSED = 5;
  localparam int ENT_DIRTY    = 6;

  typedef enum logic [1:0] {
    CAUSE_NONE   = 2'd0,
    CAUSE_ABSENT = 2'd1,
    CAUSE_WRITE  = 2'd2,
    CAUSE_PRIV   = 2'd3
  } ptw_cause_e;

  typedef enum logic {
    WALK_IDLE = 1'b0,
    WALK_WAIT = 1'b1
  } ptw_state_e;

endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
  parameter int VA_W    = 48,
  parameter int PA_W    = 52,
  parameter int IDX_W   = 9,
  parameter int OFF_W   = 12,
  parameter int LEVELS  = 4,
  parameter int ENT_B   = 8,
  localparam int LVL_W  = $clog2(LEVELS + 1),
  localparam int FRM_W  = PA_W - OFF_W,
  localparam int SHIFT  = $clog2(ENT_B)
) (
  input  logic [FRM_W-1:0] base_frame,
  input  logic [VA_W-1:0]  vaddr,
  input  logic [LVL_W-1:0] level,
  output logic [PA_W-1:0]  entry_addr
);

  logic [IDX_W-1:0] idx_arr [LEVELS];
  logic [IDX_W-1:0] idx_sel;

  for (genvar g = 0; g < LEVELS; g++) begin : g_idx
    assign idx_arr[g] = vaddr[OFF_W + g*IDX_W +: IDX_W];
  end

  always_comb begin
    idx_sel = '0;
    for (int k = 0; k < LEVELS; k++) begin
      if (LVL_W'(k + 1) == level) idx_sel = idx_arr[k];
    end
  end

  assign entry_addr = {base_frame, {OFF_W{1'b0}}} + (PA_W'(idx_sel) << SHIFT);

endmodule

// File: rtl/ptw_perm_check.sv
module ptw_perm_check
  import ptw_pkg::*;
#(
  parameter int ENT_W = 64
) (
  input  logic [ENT_W-1:0] entry,
  input  logic             is_write,
  input  logic             is_user,
  output ptw_cause_e       cause
);

  always_comb begin
    if (!entry[ENT_PRESENT])                 cause = CAUSE_ABSENT;
    else if (is_user && !entry[ENT_USER])    cause = CAUSE_PRIV;
    else if (is_write && !entry[ENT_WRITABLE]) cause = CAUSE_WRITE;
    else                                     cause = CAUSE_NONE;
  end

endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
#(
  parameter int VA_W    = 48,
  parameter int PA_W    = 52,
  parameter int ENT_W   = 64,
  parameter int IDX_W   = 9,
  parameter int OFF_W   = 12,
  parameter int LEVELS  = 4,
  localparam int LVL_W  = $clog2(LEVELS + 1),
  localparam int FRM_W  = PA_W - OFF_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic             req_write,
  input  logic             req_user,
  input  logic [PA_W-1:0]  root_base,
  output logic             mem_req_valid,
  output logic [PA_W-1:0]  mem_req_addr,
  input  logic             mem_rsp_valid,
  input  logic [ENT_W-1:0] mem_rsp_data,
  output logic             done,
  output logic [PA_W-1:0]  resp_paddr,
  output logic             resp_fault,
  output logic [1:0]       resp_cause,
  output logic [LVL_W-1:0] resp_level,
  output logic             resp_accessed,
  output logic             resp_dirty
);

  ptw_state_e       state_q;
  logic [VA_W-1:0]  va_q;
  logic             wr_q;
  logic             usr_q;
  logic [LVL_W-1:0] lvl_q;

  logic [FRM_W-1:0] gen_base;
  logic [VA_W-1:0]  gen_va;
  logic [LVL_W-1:0] gen_lvl;
  logic [PA_W-1:0]  gen_addr;
  logic [FRM_W-1:0] rsp_frame;
  ptw_cause_e       chk_cause;

  assign rsp_frame = mem_rsp_data[PA_W-1:OFF_W];
  assign req_ready = (state_q == WALK_IDLE);

  // One address generator serves both the first read and every later read.
  always_comb begin
    if (state_q == WALK_IDLE) begin
      gen_base = root_base[PA_W-1:OFF_W];
      gen_va   = req_vaddr;
      gen_lvl  = LVL_W'(LEVELS);
    end else begin
      gen_base = rsp_frame;
      gen_va   = va_q;
      gen_lvl  = lvl_q - 1'b1;
    end
  end

  ptw_addr_gen #(
    .VA_W(VA_W), .PA_W(PA_W), .IDX_W(IDX_W), .OFF_W(OFF_W),
    .LEVELS(LEVELS), .ENT_B(ENT_W/8)
  ) u_addr (
    .base_frame(gen_base),
    .vaddr     (gen_va),
    .level     (gen_lvl),
    .entry_addr(gen_addr)
  );

  ptw_perm_check #(.ENT_W(ENT_W)) u_perm (
    .entry   (mem_rsp_data),
    .is_write(wr_q),
    .is_user (usr_q),
    .cause   (chk_cause)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= WALK_IDLE;
      va_q          <= '0;
      wr_q          <= 1'b0;
      usr_q         <= 1'b0;
      lvl_q         <= '0;
      mem_req_valid <= 1'b0;
      mem_req_addr  <= '0;
      done          <= 1'b0;
      resp_paddr    <= '0;
      resp_fault    <= 1'b0;
      resp_cause    <= CAUSE_NONE;
      resp_level    <= '0;
      resp_accessed <= 1'b0;
      resp_dirty    <= 1'b0;
    end else begin
      done          <= 1'b0;
      mem_req_valid <= 1'b0;
      case (state_q)
        WALK_IDLE: begin
          if (req_valid) begin
            va_q          <= req_vaddr;
            wr_q          <= req_write;
            usr_q         <= req_user;
            lvl_q         <= LVL_W'(LEVELS);
            mem_req_valid <= 1'b1;
            mem_req_addr  <= gen_addr;
            state_q       <= WALK_WAIT;
          end
        end
        WALK_WAIT: begin
          if (mem_rsp_valid) begin
            if (chk_cause != CAUSE_NONE) begin
              done          <= 1'b1;
              resp_fault    <= 1'b1;
              resp_cause    <= chk_cause;
              resp_level    <= lvl_q;
              resp_paddr    <= '0;
              resp_accessed <= 1'b0;
              resp_dirty    <= 1'b0;
              state_q       <= WALK_IDLE;
            end else if (lvl_q == LVL_W'(1)) begin
              done          <= 1'b1;
              resp_fault    <= 1'b0;
              resp_cause    <= CAUSE_NONE;
              resp_level    <= '0;
              resp_paddr    <= {rsp_frame, va_q[OFF_W-1:0]};
              resp_accessed <= mem_rsp_data[ENT_ACCESSED];
              resp_dirty    <= mem_rsp_data[ENT_DIRTY];
              state_q       <= WALK_IDLE;
            end else begin
              lvl_q         <= lvl_q - 1'b1;
              mem_req_valid <= 1'b1;
              mem_req_addr  <= gen_addr;
            end
          end
        end
        default: state_q <= WALK_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int VA_W   = 48,
  parameter int PA_W   = 52,
  parameter int ENT_W  = 64,
  parameter int LEVELS = 4,
  localparam int LVL_W = $clog2(LEVELS + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             req_ready,
  input logic             mem_req_valid,
  input logic [PA_W-1:0]  mem_req_addr,
  input logic             mem_rsp_valid,
  input logic             done,
  input logic             resp_fault,
  input logic [1:0]       resp_cause,
  input logic [LVL_W-1:0] resp_level,
  input logic             resp_accessed,
  input logic             resp_dirty
);

  assert_entry_aligned_R2: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> (mem_req_addr[2:0] == 3'd0));

  assert_single_read_R5: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |=> !mem_req_valid);

  assert_read_only_busy_R5: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> !req_ready);

  assert_fault_coded_R9: assert property (@(posedge clk) disable iff (rst)
    (done && resp_fault) |-> (resp_cause != 2'd0 && resp_level != '0 &&
                              resp_level <= LVL_W'(LEVELS)));

  assert_success_clean_R9: assert property (@(posedge clk) disable iff (rst)
    (done && !resp_fault) |-> (resp_cause == 2'd0 && resp_level == '0));

  assert_busy_after_accept_R10: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_fault_no_ad_R12: assert property (@(posedge clk) disable iff (rst)
    (done && resp_fault) |-> (!resp_accessed && !resp_dirty));

endmodule

bind pt_walker pt_walker_chk #(
  .VA_W(VA_W), .PA_W(PA_W), .ENT_W(ENT_W), .LEVELS(LEVELS)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
  .mem_rsp_valid(mem_rsp_valid), .done(done), .resp_fault(resp_fault),
  .resp_cause(resp_cause), .resp_level(resp_level),
  .resp_accessed(resp_accessed), .resp_dirty(resp_dirty)
);

// File: tb/tb_pt_walker.sv
module tb_pt_walker;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [47:0] req_vaddr = '0;
  logic        req_write = 1'b0;
  logic        req_user = 1'b0;
  logic [51:0] root_base = '0;
  logic        mem_req_valid;
  logic [51:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic        done;
  logic [51:0] resp_paddr;
  logic        resp_fault;
  logic [1:0]  resp_cause;
  logic [2:0]  resp_level;
  logic        resp_accessed;
  logic        resp_dirty;

  always #2 clk = ~clk;

  pt_walker dut (.*);

  int checks = 0;
  int errors = 0;

  logic [63:0] pmem [logic [51:0]];
  logic [51:0] exp_q [$];
  int          pend = 0;
  logic [51:0] pend_addr;
  bit          busy = 0;
  bit          prev_done = 0;
  string       tag = "R1";

  logic        e_fault;
  logic [1:0]  e_cause;
  logic [2:0]  e_level;
  logic [51:0] e_paddr;
  logic        e_acc, e_dirty;

  localparam logic [51:0] FRAME_MASK = 52'hF_FFFF_FFFF_F000;

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s (%s): actual %h expected %h", req, tag, act, expv);
    end
  endtask

  function automatic logic [63:0] rd(input logic [51:0] a);
    return pmem.exists(a) ? pmem[a] : 64'd0;
  endfunction

  function automatic logic [47:0] mkva(input int i4, input int i3, input int i2,
                                      input int i1, input int off);
    return {9'(i4), 9'(i3), 9'(i2), 9'(i1), 12'(off)};
  endfunction

  // Behavioural reference walk over the bench memory.
  task automatic ref_walk(input logic [47:0] va, input bit wr, input bit usr,
                          input logic [51:0] root);
    logic [51:0] base;
    logic [51:0] a;
    logic [63:0] e;
    base = root & FRAME_MASK;
    e_fault = 0; e_cause = 0; e_level = 0; e_paddr = 0; e_acc = 0; e_dirty = 0;
    for (int lv = 4; lv >= 1; lv--) begin
      a = base + 52'(((va >> (12 + 9*(lv-1))) & 48'h1FF) * 8);
      exp_q.push_back(a);
      e = rd(a);
      if (!e[0])              begin e_fault = 1; e_cause = 1; end
      else if (usr && !e[2])  begin e_fault = 1; e_cause = 3; end
      else if (wr && !e[1])   begin e_fault = 1; e_cause = 2; end
      if (e_fault) begin e_level = 3'(lv); break; end
      base = e[51:0] & FRAME_MASK;
      if (lv == 1) begin
        e_paddr = base | 52'(va[11:0]);
        e_acc   = e[5];
        e_dirty = e[6];
      end
    end
  endtask

  // Memory model: one pending read, answered after two cycles.
  always @(negedge clk) begin
    mem_rsp_valid = 1'b0;
    if (pend > 0) begin
      pend--;
      if (pend == 0) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = rd(pend_addr);
      end
    end
    if (!rst && mem_req_valid) begin
      if (pend != 0 || mem_rsp_valid) chk(0, "R5", 1, 0);
      pend = 2;
      pend_addr = mem_req_addr;
    end
  end

  // Per-cycle comparison against the reference.
  always @(negedge clk) begin
    #1;
    if (!rst) begin
      if (mem_req_valid) begin
        if (exp_q.size() == 0) chk(0, "R5", 64'(mem_req_addr), 0);
        else begin
          logic [51:0] ea;
          ea = exp_q.pop_front();
          chk(mem_req_addr == ea, "R2", 64'(mem_req_addr), 64'(ea));
        end
      end
      if (busy && !done) chk(!req_ready, "R10", 64'(req_ready), 0);
      if (done && prev_done) chk(0, "R11", 1, 0);
      if (done) begin
        chk(busy, "R11", 64'(busy), 1);
        chk(exp_q.size() == 0, "R5", 64'(exp_q.size()), 0);
        chk(resp_fault == e_fault, "R9", 64'(resp_fault), 64'(e_fault));
        case (e_cause)
          2'd1:    chk(resp_cause == e_cause, "R6", 64'(resp_cause), 64'(e_cause));
          2'd2:    chk(resp_cause == e_cause, "R7", 64'(resp_cause), 64'(e_cause));
          2'd3:    chk(resp_cause == e_cause, "R8", 64'(resp_cause), 64'(e_cause));
          default: chk(resp_cause == e_cause, "R9", 64'(resp_cause), 64'(e_cause));
        endcase
        chk(resp_level == e_level, "R9", 64'(resp_level), 64'(e_level));
        if (!e_fault) chk(resp_paddr == e_paddr, "R4", 64'(resp_paddr), 64'(e_paddr));
        chk({resp_dirty, resp_accessed} == {e_dirty, e_acc}, "R12",
            64'({resp_dirty, resp_accessed}), 64'({e_dirty, e_acc}));
        busy = 0;
      end
      prev_done = done;
    end
  end

  task automatic walk(input logic [47:0] va, input bit wr, input bit usr,
                      input logic [51:0] root, input string t, input bit poke);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    tag = t;
    ref_walk(va, wr, usr, root);
    req_vaddr = va; req_write = wr; req_user = usr; root_base = root;
    req_valid = 1'b1;
    @(negedge clk);
    busy = 1;
    req_valid = 1'b0;
    if (poke) begin
      // R10: requests while busy must start nothing
      req_vaddr = mkva(0, 0, 0, 0, 0); req_write = ~wr; req_valid = 1'b1;
      repeat (3) @(negedge clk);
      req_valid = 1'b0;
    end
    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog (%s): actual hang expected done", tag);
    finish_run();
  end

  localparam logic [51:0] ROOT = 52'h0010_0000;
  localparam logic [51:0] L3A  = 52'h0020_0000;
  localparam logic [51:0] L3B  = 52'h0021_0000;
  localparam logic [51:0] L2A  = 52'h0030_0000;
  localparam logic [51:0] L2B  = 52'h0031_0000;
  localparam logic [51:0] L1A  = 52'h0040_0000;
  localparam logic [51:0] L1B  = 52'h0041_0000;
  localparam logic [63:0] FULL = 64'h67;

  initial begin
    pmem[ROOT + 52'h1A3*8] = {12'd0, L3A} | FULL;
    pmem[ROOT + 52'h1A4*8] = {12'd0, L3B} | FULL;
    pmem[L3A + 52'h0F2*8]  = {12'd0, L2A} | FULL;
    pmem[L3A + 52'h0F3*8]  = {12'd0, L2B} | FULL;
    pmem[L3B + 52'h001*8]  = {12'd0, L2A} | 64'h03;
    pmem[L3B + 52'h002*8]  = {12'd0, L2A} | 64'h01;
    pmem[L3B + 52'h003*8]  = {12'd0, L2A} | 64'h87;
    pmem[L2A + 52'h045*8]  = {12'd0, L1A} | FULL;
    pmem[L2B + 52'h010*8]  = {12'd0, L1B} | 64'h05;
    pmem[L1A + 52'h1B7*8]  = 64'h0_0888_8000 | FULL;
    pmem[L1A + 52'h1B8*8]  = 64'h0_0999_9000 | 64'h27;
    pmem[L1B + 52'h020*8]  = 64'h0_0AAA_A000 | FULL;

    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    tag = "R1";
    chk(req_ready == 1'b1, "R1", 64'(req_ready), 1);
    chk(done == 1'b0, "R1", 64'(done), 0);
    chk(mem_req_valid == 1'b0, "R1", 64'(mem_req_valid), 0);

    walk(mkva(9'h1A3, 9'h0F2, 9'h045, 9'h1B7, 12'h2A8), 1, 1, ROOT, "R4", 0);
    walk(mkva(9'h1A3, 9'h0F2, 9'h045, 9'h1B8, 12'hFFF), 0, 1, ROOT, "R12", 0);
    walk(mkva(9'h1A3, 9'h0F2, 9'h045, 9'h1B7, 12'h001), 0, 0, ROOT | 52'hABC, "R3", 0);
    walk(mkva(9'h000, 9'h0F2, 9'h045, 9'h1B7, 12'h0), 0, 0, ROOT, "R6", 0);
    walk(mkva(9'h1A3, 9'h0F2, 9'h045, 9'h1B9, 12'h0), 0, 0, ROOT, "R6", 0);
    walk(mkva(9'h1A3, 9'h0F3, 9'h010, 9'h020, 12'h123), 1, 1, ROOT, "R7", 0);
    walk(mkva(9'h1A3, 9'h0F3, 9'h010, 9'h020, 12'h123), 0, 1, ROOT, "R7", 0);
    walk(mkva(9'h1A4, 9'h001, 9'h045, 9'h1B7, 12'h040), 0, 1, ROOT, "R8", 0);
    walk(mkva(9'h1A4, 9'h001, 9'h045, 9'h1B7, 12'h040), 1, 0, ROOT, "R8", 0);
    walk(mkva(9'h1A4, 9'h002, 9'h045, 9'h1B7, 12'h040), 1, 1, ROOT, "R8", 0);
    walk(mkva(9'h1A4, 9'h003, 9'h045, 9'h1B7, 12'h777), 1, 1, ROOT, "R13", 0);
    walk(mkva(9'h1A3, 9'h0F2, 9'h045, 9'h1B7, 12'h555), 0, 1, ROOT, "R10", 1);
    tag = "R10";
    chk(exp_q.size() == 0, "R10", 64'(exp_q.size()), 0);
    finish_run();
  end

endmodule